// File: doc/BRIEF.md
# Protected-Mode Gate Dispatch Checker

This block takes one interrupt or exception dispatch request and runs it through the protected-mode gate checks. A request carries a vector number, a software/hardware origin flag and an optional error code. Alongside it come the 8-byte gate descriptor read from the interrupt table, the table limit, the fields of the target code segment, the current privilege level, the virtual-8086 flag and the inner stack selector and pointer taken from the task state. The block decides between three outcomes. It can raise a fault, given as a vector and a 16-bit error code. It can redirect to a task gate, which is handed on to a task-switch unit. Or it can enter an interrupt or trap handler.

When a handler is entered, the block returns the new code selector and instruction pointer, the new stack selector and pointer, and a mask of flag bits the core must clear. It also says whether the four data segment registers are to be zeroed. It then streams the words to push onto the new stack, one per clock, in push order. Descriptor memory reads and the task switch itself belong to other units. All descriptors arrive as inputs.

A request is accepted on a clock where `start` is high and `busy` is low. The verdict appears one clock later. A frame stream, when there is one, begins on that same clock.

Top module: `gate_dispatch`

## Requirements
- R1: With gate offset = vector×8, if offset+7 exceeds `idt_limit`, or the gate present bit (descriptor bit 47) is 0, the block raises fault vector 13. The code is vector×8 | 2 | ext, where ext = 1 for a hardware request (`soft_int`=0) and 0 for a software one.
- R2: The gate kind is descriptor bits 44:40. The accepted kinds are 0x05 (task), 0x06 (16-bit interrupt), 0x0E (32-bit interrupt), 0x07 (16-bit trap) and 0x0F (32-bit trap). Any other kind raises fault 13 with the R1 code.
- R3: A software request through a gate whose DPL (bits 46:45) is below `cpl` raises fault 13 with code vector×8 | 2. A hardware request ignores the gate DPL.
- R4: A task gate yields `task_gate`=1 with `entry_cs` equal to the gate selector (bits 31:16). No frame is produced and the mask is 0.
- R5: A stack switch takes place when the target segment is non-conforming and its DPL is below `cpl`. The new stack selector must satisfy RPL = DPL = target DPL and `ss_wdata`=1; otherwise the block raises fault 10 with code (selector & 0xFFFC) | ext. If those checks pass but `ss_present`=0, it raises fault 12 with the same code.
- R6: If there is no stack switch while `vm86`=1, the block raises fault 13 with code (gate selector & 0xFFFC).
- R7: The entry offset is bits 63:48 and 15:0 of the descriptor for 32-bit gates, and only bits 15:0 for 16-bit gates. An entry offset above `cs_limit` raises fault 13 with code 0. This check comes after R5 and R6.
- R8: The frame holds 3 items, plus 2 with a stack switch, plus 4 more when the switch is from virtual-8086 mode, plus 1 with an error code. Each item is 4 bytes on a 32-bit gate and 2 bytes on a 16-bit gate. `entry_esp` is the base pointer minus the frame size. The base pointer is `tss_esp` with a switch and `cur_esp` without one. `entry_ss` is `tss_ss` or `cur_ss` in the same way.
- R9: Frame words stream in this order: [GS, FS, DS, ES when switching from virtual-8086 mode], [old SS, old ESP when switching], EFLAGS, old CS, old EIP, [error code]. `push_last` marks the final word.
- R10: On a 16-bit gate every pushed word is truncated to its low 16 bits.
- R11: On handler entry, `clr_mask` sets bits 8, 14, 16 and 17, and also bit 9 for an interrupt gate. `zero_dsegs` is 1 only for a switch from virtual-8086 mode. On a fault, both are 0, and so are `frame_bytes` and the entry fields.
- R12: `done` rises exactly one clock after an accepted `start`, and the first frame word is valid in that same clock. Words follow on consecutive clocks. A `start` while `busy` is ignored and produces no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request strobe |
| vector | input | 8 | Interrupt vector |
| soft_int | input | 1 | 1 = software request |
| has_err | input | 1 | Push an error code |
| err_code | input | 32 | Error code value |
| gate_desc | input | 64 | Gate descriptor |
| idt_limit | input | 16 | Interrupt table limit |
| cpl | input | 2 | Current privilege level |
| vm86 | input | 1 | Virtual-8086 mode active |
| cs_conforming | input | 1 | Target code segment is conforming |
| cs_dpl | input | 2 | Target code segment DPL |
| cs_limit | input | 32 | Target code segment limit |
| tss_ss | input | 16 | Inner stack selector |
| tss_esp | input | 32 | Inner stack pointer |
| ss_dpl | input | 2 | Inner stack segment DPL |
| ss_wdata | input | 1 | Inner stack is writable data |
| ss_present | input | 1 | Inner stack present |
| cur_cs | input | 16 | Current code selector |
| cur_eip | input | 32 | Current instruction pointer |
| cur_ss | input | 16 | Current stack selector |
| cur_esp | input | 32 | Current stack pointer |
| eflags | input | 32 | Current flags |
| old_gs | input | 16 | GS selector |
| old_fs | input | 16 | FS selector |
| old_ds | input | 16 | DS selector |
| old_es | input | 16 | ES selector |
| busy | output | 1 | Frame stream in progress |
| done | output | 1 | Verdict valid |
| fault | output | 1 | Request faulted |
| fault_vec | output | 8 | Fault vector |
| fault_code | output | 16 | Fault error code |
| task_gate | output | 1 | Task gate selected |
| entry_cs | output | 16 | New code selector |
| entry_eip | output | 32 | New instruction pointer |
| entry_ss | output | 16 | New stack selector |
| entry_esp | output | 32 | New stack pointer |
| clr_mask | output | 32 | Flag bits to clear |
| frame_bytes | output | 6 | Frame size in bytes |
| zero_dsegs | output | 1 | Zero GS/FS/DS/ES |
| push_valid | output | 1 | Frame word valid |
| push_word | output | 32 | Frame word |
| push_last | output | 1 | Final frame word |

## Verification
Every verdict field (fault, vector, code, entry state, mask, size) is due one clock after the accepting edge. The bench drives `start` on a falling edge and reads the verdict on the next falling edge. Frame word k is due k clocks after the verdict, so the bench reads one word per following falling edge and then confirms the stream has stopped. For the ignored-start case, the bench raises `start` during a stream and confirms `done` stays low on the next falling edge.

// File: rtl/gate_dispatch_pkg.sv
package gate_dispatch_pkg;
  localparam logic [7:0] EXC_TS = 8'd10;
  localparam logic [7:0] EXC_SS = 8'd12;
  localparam logic [7:0] EXC_GP = 8'd13;

  localparam logic [4:0] K_TASK   = 5'h05;
  localparam logic [4:0] K_INT16  = 5'h06;
  localparam logic [4:0] K_TRAP16 = 5'h07;
  localparam logic [4:0] K_INT32  = 5'h0E;
  localparam logic [4:0] K_TRAP32 = 5'h0F;

  typedef struct packed {
    logic [31:0] offset;
    logic [15:0] sel;
    logic [4:0]  kind;
    logic [1:0]  dpl;
    logic        present;
  } gate_t;

  function automatic gate_t split_gate(input logic [63:0] d);
    gate_t g;
    g.offset  = {d[63:48], d[15:0]};
    g.sel     = d[31:16];
    g.kind    = d[44:40];
    g.dpl     = d[46:45];
    g.present = d[47];
    return g;
  endfunction

  function automatic logic kind_ok(input logic [4:0] k);
    return (k == K_TASK) || (k == K_INT16) || (k == K_TRAP16) ||
           (k == K_INT32) || (k == K_TRAP32);
  endfunction

  // items on the stack: flags, cs, eip, optional extras
  function automatic logic [3:0] item_count(input logic sw, input logic vm,
                                            input logic err);
    logic [3:0] n;
    n = 4'd3;
    if (sw) n = n + 4'd2;
    if (sw && vm) n = n + 4'd4;
    if (err) n = n + 4'd1;
    return n;
  endfunction

  function automatic logic [5:0] frame_size(input logic [3:0] n, input logic w32);
    return w32 ? {n, 2'b00} : {1'b0, n, 1'b0};
  endfunction

  function automatic logic [31:0] flag_mask(input logic intr);
    logic [31:0] m;
    m = '0;
    m[8]  = 1'b1;
    m[14] = 1'b1;
    m[16] = 1'b1;
    m[17] = 1'b1;
    m[9]  = intr;
    return m;
  endfunction
endpackage

// File: rtl/gate_dispatch_check.sv
module gate_dispatch_check
  import gate_dispatch_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int LIM_W = 16,
  localparam int OFF_W = VEC_W + 3,
  localparam int CMP_W = ((OFF_W > LIM_W) ? OFF_W : LIM_W) + 1
) (
  input  logic [VEC_W-1:0] vector,
  input  logic             soft_int,
  input  logic [63:0]      gate_desc,
  input  logic [LIM_W-1:0] idt_limit,
  input  logic [1:0]       cpl,
  input  logic             vm86,
  input  logic             cs_conforming,
  input  logic [1:0]       cs_dpl,
  input  logic [31:0]      cs_limit,
  input  logic [15:0]      tss_ss,
  input  logic [1:0]       ss_dpl,
  input  logic             ss_wdata,
  input  logic             ss_present,
  output logic             fault,
  output logic [7:0]       fvec,
  output logic [15:0]      fcode,
  output logic             task_hit,
  output logic             sw,
  output logic             w32,
  output logic             intr,
  output logic [15:0]      gsel,
  output logic [31:0]      entry_off
);
  gate_t g;
  logic ext, lim_hit, ss_bad, eip_bad;
  logic [OFF_W-1:0] gate_off;
  logic [CMP_W-1:0] end_off;
  logic [15:0] gp_code, ss_code, cs_code;

  assign g         = split_gate(gate_desc);
  assign ext       = ~soft_int;
  assign gate_off  = {vector, 3'b000};
  assign end_off   = CMP_W'(gate_off) + CMP_W'(7);
  assign lim_hit   = end_off > CMP_W'(idt_limit);
  assign gp_code   = 16'(gate_off) | 16'd2 | {15'd0, ext};
  assign w32       = g.kind[3];
  assign intr      = (g.kind[2:0] == 3'd6);
  assign gsel      = g.sel;
  assign entry_off = w32 ? g.offset : {16'd0, g.offset[15:0]};
  assign sw        = ~cs_conforming && (cs_dpl < cpl);
  assign ss_bad    = (tss_ss[1:0] != cs_dpl) || (ss_dpl != cs_dpl) || ~ss_wdata;
  assign ss_code   = {tss_ss[15:2], 1'b0, ext};
  assign cs_code   = {g.sel[15:2], 2'b00};
  assign eip_bad   = entry_off > cs_limit;

  always_comb begin
    fault    = 1'b0;
    fvec     = '0;
    fcode    = '0;
    task_hit = 1'b0;
    if (lim_hit || !g.present || !kind_ok(g.kind)) begin
      fault = 1'b1; fvec = EXC_GP; fcode = gp_code;
    end else if (soft_int && (g.dpl < cpl)) begin
      fault = 1'b1; fvec = EXC_GP; fcode = {gp_code[15:1], 1'b0};
    end else if (g.kind == K_TASK) begin
      task_hit = 1'b1;
    end else if (sw) begin
      if (ss_bad) begin
        fault = 1'b1; fvec = EXC_TS; fcode = ss_code;
      end else if (!ss_present) begin
        fault = 1'b1; fvec = EXC_SS; fcode = ss_code;
      end else if (eip_bad) begin
        fault = 1'b1; fvec = EXC_GP; fcode = '0;
      end
    end else begin
      if (vm86) begin
        fault = 1'b1; fvec = EXC_GP; fcode = cs_code;
      end else if (eip_bad) begin
        fault = 1'b1; fvec = EXC_GP; fcode = '0;
      end
    end
  end
endmodule

// File: rtl/gate_dispatch_frame.sv
module gate_dispatch_frame
  import gate_dispatch_pkg::*;
#(
  parameter int DEPTH = 10,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                   sw,
  input  logic                   vm86,
  input  logic                   w32,
  input  logic                   has_err,
  input  logic [31:0]            err_code,
  input  logic [31:0]            eflags,
  input  logic [31:0]            cur_eip,
  input  logic [31:0]            cur_esp,
  input  logic [15:0]            cur_cs,
  input  logic [15:0]            cur_ss,
  input  logic [15:0]            old_gs,
  input  logic [15:0]            old_fs,
  input  logic [15:0]            old_ds,
  input  logic [15:0]            old_es,
  output logic [DEPTH-1:0][31:0] words,
  output logic [CW-1:0]          count,
  output logic [5:0]             bytes
);
  logic [3:0]  n_items;
  logic [31:0] lo_mask;

  assign n_items = item_count(sw, vm86, has_err);
  assign count   = CW'(n_items);
  assign bytes   = frame_size(n_items, w32);
  assign lo_mask = w32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;

  always_comb begin
    logic [CW-1:0] p;
    words = '0;
    p = '0;
    if (sw && vm86) begin
      words[p] = {16'd0, old_gs}; p = p + 1'b1;
      words[p] = {16'd0, old_fs}; p = p + 1'b1;
      words[p] = {16'd0, old_ds}; p = p + 1'b1;
      words[p] = {16'd0, old_es}; p = p + 1'b1;
    end
    if (sw) begin
      words[p] = {16'd0, cur_ss}; p = p + 1'b1;
      words[p] = cur_esp;         p = p + 1'b1;
    end
    words[p] = eflags;          p = p + 1'b1;
    words[p] = {16'd0, cur_cs}; p = p + 1'b1;
    words[p] = cur_eip;         p = p + 1'b1;
    if (has_err) words[p] = err_code;
    for (int i = 0; i < DEPTH; i++) words[i] = words[i] & lo_mask;
  end
endmodule

// File: rtl/gate_dispatch_emit.sv
module gate_dispatch_emit #(
  parameter int DEPTH = 10,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [DEPTH-1:0][31:0] words,
  input  logic [CW-1:0]          count,
  output logic                   push_valid,
  output logic [31:0]            push_word,
  output logic                   push_last
);
  logic [DEPTH-1:0][31:0] buf_q;
  logic [CW-1:0] idx_q, cnt_q;
  logic active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q    <= '0;
      idx_q    <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (load) begin
      buf_q    <= words;
      idx_q    <= '0;
      cnt_q    <= count;
      active_q <= (count != '0);
    end else if (active_q) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == cnt_q - 1'b1) active_q <= 1'b0;
    end
  end

  assign push_valid = active_q;
  assign push_word  = active_q ? buf_q[idx_q] : '0;
  assign push_last  = active_q && (idx_q == cnt_q - 1'b1);
endmodule

// File: rtl/gate_dispatch.sv
module gate_dispatch
  import gate_dispatch_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int LIM_W = 16,
  parameter int DEPTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VEC_W-1:0] vector,
  input  logic             soft_int,
  input  logic             has_err,
  input  logic [31:0]      err_code,
  input  logic [63:0]      gate_desc,
  input  logic [LIM_W-1:0] idt_limit,
  input  logic [1:0]       cpl,
  input  logic             vm86,
  input  logic             cs_conforming,
  input  logic [1:0]       cs_dpl,
  input  logic [31:0]      cs_limit,
  input  logic [15:0]      tss_ss,
  input  logic [31:0]      tss_esp,
  input  logic [1:0]       ss_dpl,
  input  logic             ss_wdata,
  input  logic             ss_present,
  input  logic [15:0]      cur_cs,
  input  logic [31:0]      cur_eip,
  input  logic [15:0]      cur_ss,
  input  logic [31:0]      cur_esp,
  input  logic [31:0]      eflags,
  input  logic [15:0]      old_gs,
  input  logic [15:0]      old_fs,
  input  logic [15:0]      old_ds,
  input  logic [15:0]      old_es,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [7:0]       fault_vec,
  output logic [15:0]      fault_code,
  output logic             task_gate,
  output logic [15:0]      entry_cs,
  output logic [31:0]      entry_eip,
  output logic [15:0]      entry_ss,
  output logic [31:0]      entry_esp,
  output logic [31:0]      clr_mask,
  output logic [5:0]       frame_bytes,
  output logic             zero_dsegs,
  output logic             push_valid,
  output logic [31:0]      push_word,
  output logic             push_last
);
  localparam int CW = $clog2(DEPTH + 1);

  logic c_fault, c_task, c_sw, c_w32, c_intr, accept, enter;
  logic [7:0] c_vec;
  logic [15:0] c_code, c_gsel;
  logic [31:0] c_off;
  logic [DEPTH-1:0][31:0] f_words;
  logic [CW-1:0] f_count;
  logic [5:0] f_bytes;

  gate_dispatch_check #(.VEC_W(VEC_W), .LIM_W(LIM_W)) u_check (
    .vector(vector), .soft_int(soft_int), .gate_desc(gate_desc),
    .idt_limit(idt_limit), .cpl(cpl), .vm86(vm86),
    .cs_conforming(cs_conforming), .cs_dpl(cs_dpl), .cs_limit(cs_limit),
    .tss_ss(tss_ss), .ss_dpl(ss_dpl), .ss_wdata(ss_wdata),
    .ss_present(ss_present), .fault(c_fault), .fvec(c_vec), .fcode(c_code),
    .task_hit(c_task), .sw(c_sw), .w32(c_w32), .intr(c_intr),
    .gsel(c_gsel), .entry_off(c_off)
  );

  gate_dispatch_frame #(.DEPTH(DEPTH)) u_frame (
    .sw(c_sw), .vm86(vm86), .w32(c_w32), .has_err(has_err),
    .err_code(err_code), .eflags(eflags), .cur_eip(cur_eip),
    .cur_esp(cur_esp), .cur_cs(cur_cs), .cur_ss(cur_ss),
    .old_gs(old_gs), .old_fs(old_fs), .old_ds(old_ds), .old_es(old_es),
    .words(f_words), .count(f_count), .bytes(f_bytes)
  );

  assign accept = start && !busy;
  assign enter  = !c_fault && !c_task;

  gate_dispatch_emit #(.DEPTH(DEPTH)) u_emit (
    .clk(clk), .rst_n(rst_n), .load(accept && enter),
    .words(f_words), .count(f_count),
    .push_valid(push_valid), .push_word(push_word), .push_last(push_last)
  );

  assign busy = push_valid && !push_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; fault <= 1'b0; fault_vec <= '0; fault_code <= '0;
      task_gate <= 1'b0; entry_cs <= '0; entry_eip <= '0; entry_ss <= '0;
      entry_esp <= '0; clr_mask <= '0; frame_bytes <= '0; zero_dsegs <= 1'b0;
    end else begin
      done <= accept;
      if (accept) begin
        fault       <= c_fault;
        fault_vec   <= c_vec;
        fault_code  <= c_code;
        task_gate   <= c_task;
        entry_cs    <= c_fault ? 16'd0 : c_gsel;
        entry_eip   <= enter ? c_off : 32'd0;
        entry_ss    <= !enter ? 16'd0 : (c_sw ? tss_ss : cur_ss);
        entry_esp   <= !enter ? 32'd0 : ((c_sw ? tss_esp : cur_esp) - 32'(f_bytes));
        clr_mask    <= enter ? flag_mask(c_intr) : 32'd0;
        frame_bytes <= enter ? f_bytes : 6'd0;
        zero_dsegs  <= enter && c_sw && vm86;
      end
    end
  end
endmodule

// File: rtl/gate_dispatch_chk.sv
module gate_dispatch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        fault,
  input logic [7:0]  fault_vec,
  input logic [5:0]  frame_bytes,
  input logic        task_gate,
  input logic [31:0] clr_mask,
  input logic        push_valid,
  input logic        push_last
);
  // R12
  start_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> done);
  // R12
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy |=> !done);
  // R9
  last_in_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_last |-> push_valid);
  // R9
  stream_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_last |=> !push_valid);
  // R11
  entry_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && !task_gate |-> (clr_mask & 32'h0003_4100) == 32'h0003_4100);
  // R11
  fault_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> frame_bytes == 6'd0 && !push_valid);
  // R5
  fault_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> fault_vec == 8'd10 || fault_vec == 8'd12 || fault_vec == 8'd13);
endmodule

bind gate_dispatch gate_dispatch_chk i_chk (.*);

// File: tb/test_gate_dispatch.sv
`timescale 1ns/1ps
module test_gate_dispatch;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] vector;
  logic soft_int, has_err, vm86, cs_conforming, ss_wdata, ss_present;
  logic [31:0] err_code, cs_limit, tss_esp, cur_eip, cur_esp, eflags;
  logic [63:0] gate_desc;
  logic [15:0] idt_limit, tss_ss, cur_cs, cur_ss, old_gs, old_fs, old_ds, old_es;
  logic [1:0] cpl, cs_dpl, ss_dpl;
  logic busy, done, fault, task_gate, zero_dsegs, push_valid, push_last;
  logic [7:0] fault_vec;
  logic [15:0] fault_code, entry_cs, entry_ss;
  logic [31:0] entry_eip, entry_esp, clr_mask, push_word;
  logic [5:0] frame_bytes;

  gate_dispatch i_gate_dispatch (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  // expected result
  bit e_fault, e_task;
  logic [7:0] e_vec;
  logic [15:0] e_code, e_cs, e_ss;
  logic [31:0] e_eip, e_esp, e_mask;
  logic [5:0] e_bytes;
  bit e_zero, e_w32;
  string e_req;
  logic [31:0] e_words [12];
  int e_n;

  task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_gate(input logic [31:0] off, input logic [15:0] sel,
                                          input logic [4:0] kind, input logic [1:0] dpl,
                                          input logic p);
    return {off[31:16], p, dpl, kind, 8'd0, sel, off[15:0]};
  endfunction

  task automatic push_exp(input logic [31:0] w);
    e_words[e_n] = e_w32 ? w : {16'd0, w[15:0]};
    e_n++;
  endtask

  task automatic raise(input logic [7:0] v, input logic [15:0] c, input string r);
    e_fault = 1; e_vec = v; e_code = c; e_req = r;
  endtask

  task automatic model();
    logic [4:0] kind;
    logic [31:0] tgt, base;
    logic [15:0] sel;
    bit ext, p, sw;
    int gbase;
    e_fault = 0; e_task = 0; e_n = 0; e_zero = 0; e_req = "R8";
    kind = gate_desc[44:40]; p = gate_desc[47]; sel = gate_desc[31:16];
    ext = !soft_int;
    gbase = int'(vector) * 8;
    if (gbase + 7 > int'(idt_limit) || !p) begin
      raise(13, 16'(gbase + 2 + int'(ext)), "R1"); return;
    end
    if (!(kind == 5 || kind == 6 || kind == 7 || kind == 14 || kind == 15)) begin
      raise(13, 16'(gbase + 2 + int'(ext)), "R2"); return;
    end
    if (soft_int && gate_desc[46:45] < cpl) begin
      raise(13, 16'(gbase + 2), "R3"); return;
    end
    if (kind == 5) begin
      e_task = 1; e_cs = sel; e_req = "R4"; return;
    end
    e_w32 = (kind >= 14);
    tgt = e_w32 ? {gate_desc[63:48], gate_desc[15:0]} : {16'd0, gate_desc[15:0]};
    sw = !cs_conforming && cs_dpl < cpl;
    if (sw) begin
      if (tss_ss[1:0] != cs_dpl || ss_dpl != cs_dpl || !ss_wdata) begin
        raise(10, (tss_ss & 16'hFFFC) | 16'(ext), "R5"); return;
      end
      if (!ss_present) begin
        raise(12, (tss_ss & 16'hFFFC) | 16'(ext), "R5"); return;
      end
    end else if (vm86) begin
      raise(13, sel & 16'hFFFC, "R6"); return;
    end
    if (tgt > cs_limit) begin
      raise(13, 16'd0, "R7"); return;
    end
    if (sw && vm86) begin
      push_exp(old_gs); push_exp(old_fs); push_exp(old_ds); push_exp(old_es);
      e_zero = 1;
    end
    if (sw) begin push_exp(cur_ss); push_exp(cur_esp); end
    push_exp(eflags); push_exp(cur_cs); push_exp(cur_eip);
    if (has_err) push_exp(err_code);
    e_bytes = 6'(e_n * (e_w32 ? 4 : 2));
    base = sw ? tss_esp : cur_esp;
    e_esp = base - 32'(e_bytes);
    e_ss = sw ? tss_ss : cur_ss;
    e_cs = sel; e_eip = tgt;
    e_mask = 32'h0003_4100 | ((kind[2:0] == 3'd6) ? 32'h200 : 32'h0);
  endtask

  task automatic run(input bit poke);
    model();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk_eq("R12 done one clock after start", done, 1);
    chk_eq({e_req, " fault flag"}, fault, e_fault);
    if (e_fault) begin
      chk_eq({e_req, " fault vector"}, fault_vec, e_vec);
      chk_eq({e_req, " fault code"}, fault_code, e_code);
      chk_eq("R11 no frame on fault", {push_valid, frame_bytes, clr_mask}, 0);
    end else if (e_task) begin
      chk_eq("R4 task flag", task_gate, 1);
      chk_eq("R4 task selector", entry_cs, e_cs);
      chk_eq("R4 no frame", {push_valid, frame_bytes}, 0);
    end else begin
      chk_eq("R7 entry cs:eip", {entry_cs, entry_eip}, {e_cs, e_eip});
      chk_eq("R8 entry ss:esp", {entry_ss, entry_esp}, {e_ss, e_esp});
      chk_eq("R8 frame bytes", frame_bytes, e_bytes);
      chk_eq("R11 clear mask", clr_mask, e_mask);
      chk_eq("R11 zero data segs", zero_dsegs, e_zero);
      for (int i = 0; i < e_n; i++) begin
        if (i == 1 && poke) chk_eq("R12 start while busy ignored", done, 0);
        chk_eq(e_w32 ? "R9 frame valid" : "R10 frame valid", push_valid, 1);
        chk_eq(e_w32 ? "R9 frame word" : "R10 frame word", push_word, e_words[i]);
        chk_eq("R9 last marker", push_last, (i == e_n - 1));
        if (i == 0 && poke) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      chk_eq("R9 stream ends", push_valid, 0);
    end
  endtask

  task automatic base_case();
    vector = 8'h21; soft_int = 0; has_err = 0; err_code = 32'hDEAD_BEEF;
    gate_desc = mk_gate(32'h0012_3456, 16'h0008, 5'h0E, 2'd3, 1'b1);
    idt_limit = 16'hFFFF; cpl = 2'd3; vm86 = 0; cs_conforming = 0; cs_dpl = 2'd0;
    cs_limit = 32'hFFFF_FFFF; tss_ss = 16'h0010; tss_esp = 32'h0000_8000;
    ss_dpl = 2'd0; ss_wdata = 1; ss_present = 1;
    cur_cs = 16'h001B; cur_eip = 32'h1234_5678; cur_ss = 16'h0023;
    cur_esp = 32'hABCD_EF00; eflags = 32'h0002_0202;
    old_gs = 16'h0033; old_fs = 16'h0043; old_ds = 16'h0053; old_es = 16'h0063;
  endtask

  task automatic random_case();
    logic [4:0] kinds [6];
    kinds = '{5'h05, 5'h06, 5'h07, 5'h0E, 5'h0F, 5'h00};
    kinds[5] = 5'($urandom);
    vector = 8'($urandom); soft_int = 1'($urandom); has_err = 1'($urandom);
    err_code = $urandom; cpl = 2'($urandom); cs_dpl = 2'($urandom);
    gate_desc = mk_gate($urandom, 16'($urandom), kinds[$urandom % 6],
                        2'($urandom), ($urandom % 10) != 0);
    idt_limit = ($urandom % 8 == 0) ? 16'($urandom) : 16'hFFFF;
    vm86 = ($urandom % 4 == 0); cs_conforming = 1'($urandom);
    cs_limit = ($urandom % 6 == 0) ? $urandom : 32'hFFFF_FFFF;
    tss_ss = {14'($urandom), ($urandom % 10 == 0) ? 2'($urandom) : cs_dpl};
    ss_dpl = ($urandom % 10 == 0) ? 2'($urandom) : cs_dpl;
    ss_wdata = ($urandom % 10) != 0; ss_present = ($urandom % 10) != 0;
    tss_esp = $urandom; cur_cs = 16'($urandom); cur_eip = $urandom;
    cur_ss = 16'($urandom); cur_esp = $urandom; eflags = $urandom;
    old_gs = 16'($urandom); old_fs = 16'($urandom);
    old_ds = 16'($urandom); old_es = 16'($urandom);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd5150));
    base_case();
    repeat (3) @(negedge clk);
    chk_eq("R12 reset state", {done, busy, push_valid, fault, clr_mask}, 0);
    rst_n = 1'b1;
    // R8/R9: stack switch, 32-bit interrupt gate with error code
    has_err = 1; run(0);
    // R1: limit overflow, hardware request
    base_case(); vector = 8'h20; idt_limit = 16'h0105; run(0);
    // R1: not present, software
    base_case(); soft_int = 1; gate_desc[47] = 0; run(0);
    // R2: unknown kind
    base_case(); gate_desc[44:40] = 5'h0C; run(0);
    // R3: software through low-DPL gate; hardware passes
    base_case(); soft_int = 1; gate_desc[46:45] = 2'd0; run(0);
    soft_int = 0; run(0);
    // R4: task gate
    base_case(); gate_desc[44:40] = 5'h05; run(0);
    // R8/R11: switch from virtual-8086, trap gate
    base_case(); vm86 = 1; gate_desc[44:40] = 5'h0F; run(0);
    // R6: virtual-8086 without privilege change
    base_case(); vm86 = 1; cs_dpl = 2'd3; run(0);
    // R5: stack RPL mismatch, then not present
    base_case(); tss_ss = 16'h0011; run(0);
    base_case(); ss_present = 0; run(0);
    // R7: entry beyond limit
    base_case(); cs_limit = 32'h0000_1000; run(0);
    // R10: 16-bit trap gate, same level, error code
    base_case(); cs_dpl = 2'd3; gate_desc[44:40] = 5'h07; has_err = 1; run(0);
    // R12: start during stream
    base_case(); run(1);
    for (int k = 0; k < 400; k++) begin
      random_case();
      run(($urandom % 8) == 0);
    end
    report();
  end
endmodule